// File: doc/BRIEF.md
# Two-Level Page Walker with Accessed/Dirty Write-Back

This block turns a 32-bit linear address into a physical address. It walks a two-level page table held in memory. It first reads the directory entry selected by the top ten address bits. When that entry points to a page table, it then reads the table entry selected by the next ten bits. When large pages are enabled and the directory entry has its size bit set, the directory entry maps a 4 MB page directly and no second read is made. Every entry is checked for presence, and for write permission when the request is a write. The requester gets exactly one outcome per request: a one-cycle done pulse with the physical address, or a one-cycle fault pulse.

The walker keeps the accessed and dirty flags of the entries up to date. Once the whole translation has passed its checks, it sets the accessed flag in each entry it used, and only in entries where that flag is still clear. For a write, the block presents the translated address and raises an await-commit signal. It then waits until the requester reports that the store has really been performed. Only after that does it set the dirty flag, and only in the entry that maps the final page. Each flag update is a full 32-bit write of the modified entry. The write is issued only when a flag actually changes. Memory reads use a request/response pair with one read outstanding. Memory writes are taken in the cycle they are requested.

Top module: `page_walker`

## Requirements
- R1: After reset the block is idle: `done`, `fault`, `mem_req` and `await_commit` are all low.
- R2: The directory entry is read at `dir_base + linear[31:22]*4`. For a 4 KB page, the table entry is read at `{pde[31:12], linear[21:12], 2'b00}`, and the physical address is `{pte[31:12], linear[11:0]}`.
- R3: When `large_en` is high and directory bit 7 is set, the physical address is `{pde[31:22], linear[21:0]}`, and only one memory read is made.
- R4: When `large_en` is low, directory bit 7 is ignored and the 4 KB two-level walk is performed.
- R5: A fault is reported when the present flag (bit 0) is clear at either level, or when a write meets a clear writable flag (bit 1) at either level. A faulting walk writes nothing to memory.
- R6: After a translation passes, the accessed flag (bit 5) is set in each entry it used that had the flag clear. Each update is a full-word write of the modified entry. No write is issued for an entry whose flag is already set. The directory entry is not written when the table-level check faults.
- R7: The dirty flag (bit 6) is set only in the entry that maps the final page. That is the table entry for a 4 KB page, or the directory entry for a large page. It is never set in a directory entry that points to a table.
- R8: For a write, `await_commit` stays high with `phys_addr` valid until `commit` is seen. The dirty write-back is issued only after `commit`, and only if the flag was clear. Reads never wait for `commit` and never set the dirty flag.
- R9: Each accepted request produces exactly one single-cycle pulse, either on `done` or on `fault`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Start a translation (taken when idle) |
| req_linear | input | 32 | Linear address to translate |
| req_write | input | 1 | 1 = write access, 0 = read access |
| dir_base | input | 32 | Base address of the page directory |
| large_en | input | 1 | Enables 4 MB pages via directory bit 7 |
| commit | input | 1 | The final write access has been performed |
| mem_req | output | 1 | Memory request strobe (one cycle) |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Memory word address |
| mem_wdata | output | 32 | Write data (modified entry) |
| mem_rvalid | input | 1 | Read data is valid |
| mem_rdata | input | 32 | Read data |
| await_commit | output | 1 | Translation ready, waiting for commit of a write |
| done | output | 1 | Translation complete pulse |
| fault | output | 1 | Translation fault pulse |
| phys_addr | output | 32 | Translated address, valid with `done` and `await_commit` |

## Verification
The assertions assume that `mem_rvalid` comes only in answer to an outstanding read. They also assume that `commit` is raised only while `await_commit` is high, and that `req_valid` is raised only while the walker is idle. The bench memory model answers each read exactly once after a fixed two-cycle latency. The bench driver issues a new request only after the previous done or fault pulse has been seen. It drives `commit` only in cycles where it observes `await_commit`, sometimes after a long hold-off, so that any early dirty write-back would show up in the memory contents.

// File: rtl/walk_pkg.sv
package walk_pkg;
    localparam int AW     = 32;
    localparam int IDX_W  = 10;
    localparam int OFS_W  = IDX_W + 2;
    localparam int LOFS_W = OFS_W + IDX_W;

    localparam int P_BIT  = 0;
    localparam int W_BIT  = 1;
    localparam int A_BIT  = 5;
    localparam int D_BIT  = 6;
    localparam int PS_BIT = 7;

    typedef enum logic [3:0] {
        IDLE, READ_PDE, UPD_PDE, READ_PTE, UPD_PTE,
        WAIT_COMMIT, SET_DIRTY, DONE, FAULT
    } walk_state_t;

    typedef struct packed {
        walk_state_t     st;
        logic [AW-1:0]   lin;
        logic            wr;
        logic [AW-1:0]   base;
        logic            big_ok;
        logic            big;
        logic            issued;
        logic [AW-1:0]   pde;
        logic [AW-1:0]   pte;
    } walk_regs_t;
endpackage

// File: rtl/walk_entry_check.sv
module walk_entry_check (
    input  logic present,
    input  logic writable,
    input  logic is_write,
    output logic ok
);
    always_comb begin
        ok = present && (!is_write || writable);
    end
endmodule

// File: rtl/walk_addr_gen.sv
module walk_addr_gen
    import walk_pkg::*;
(
    input  logic [AW-1:0]       base,
    input  logic [AW-1:0]       lin,
    input  logic [AW-OFS_W-1:0] pde_hi,
    input  logic [AW-OFS_W-1:0] pte_hi,
    output logic [AW-1:0]       pde_addr,
    output logic [AW-1:0]       pte_addr,
    output logic [AW-1:0]       phys_small,
    output logic [AW-1:0]       phys_large
);
    localparam int PAD_W = AW - IDX_W - 2;

    always_comb begin
        pde_addr   = base + {{PAD_W{1'b0}}, lin[AW-1 -: IDX_W], 2'b00};
        pte_addr   = {pde_hi, lin[LOFS_W-1 -: IDX_W], 2'b00};
        phys_small = {pte_hi, lin[OFS_W-1:0]};
        phys_large = {pde_hi[AW-OFS_W-1 -: AW-LOFS_W], lin[LOFS_W-1:0]};
    end
endmodule

// File: rtl/page_walker.sv
module page_walker
    import walk_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [AW-1:0] req_linear,
    input  logic          req_write,
    input  logic [AW-1:0] dir_base,
    input  logic          large_en,
    input  logic          commit,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [AW-1:0] mem_wdata,
    input  logic          mem_rvalid,
    input  logic [AW-1:0] mem_rdata,
    output logic          await_commit,
    output logic          done,
    output logic          fault,
    output logic [AW-1:0] phys_addr
);
    walk_regs_t r_d, r_q;

    logic [AW-1:0] pde_addr, pte_addr, phys_small, phys_large;
    logic          rd_ok;
    logic [AW-1:0] fin_q, fin_addr;
    walk_state_t   after_xlat;

    walk_addr_gen u_addr (
        .base       (r_q.base),
        .lin        (r_q.lin),
        .pde_hi     (r_q.pde[AW-1:OFS_W]),
        .pte_hi     (r_q.pte[AW-1:OFS_W]),
        .pde_addr   (pde_addr),
        .pte_addr   (pte_addr),
        .phys_small (phys_small),
        .phys_large (phys_large)
    );

    walk_entry_check u_chk (
        .present  (mem_rdata[P_BIT]),
        .writable (mem_rdata[W_BIT]),
        .is_write (r_q.wr),
        .ok       (rd_ok)
    );

    always_comb begin
        r_d          = r_q;
        mem_req      = 1'b0;
        mem_we       = 1'b0;
        mem_addr     = pde_addr;
        mem_wdata    = '0;
        fin_q        = r_q.big ? r_q.pde : r_q.pte;
        fin_addr     = r_q.big ? pde_addr : pte_addr;
        after_xlat   = r_q.wr ? WAIT_COMMIT : DONE;
        done         = (r_q.st == DONE);
        fault        = (r_q.st == FAULT);
        await_commit = (r_q.st == WAIT_COMMIT);
        phys_addr    = r_q.big ? phys_large : phys_small;

        unique case (r_q.st)
            IDLE: begin
                if (req_valid) begin
                    r_d.st     = READ_PDE;
                    r_d.lin    = req_linear;
                    r_d.wr     = req_write;
                    r_d.base   = dir_base;
                    r_d.big_ok = large_en;
                    r_d.big    = 1'b0;
                    r_d.issued = 1'b0;
                end
            end
            READ_PDE: begin
                mem_req    = !r_q.issued;
                mem_addr   = pde_addr;
                r_d.issued = 1'b1;
                if (r_q.issued && mem_rvalid) begin
                    r_d.pde    = mem_rdata;
                    r_d.issued = 1'b0;
                    r_d.big    = r_q.big_ok && mem_rdata[PS_BIT];
                    if (!rd_ok)
                        r_d.st = FAULT;
                    else if (r_q.big_ok && mem_rdata[PS_BIT])
                        r_d.st = !mem_rdata[A_BIT] ? UPD_PDE : after_xlat;
                    else
                        r_d.st = READ_PTE;
                end
            end
            READ_PTE: begin
                mem_req    = !r_q.issued;
                mem_addr   = pte_addr;
                r_d.issued = 1'b1;
                if (r_q.issued && mem_rvalid) begin
                    r_d.pte    = mem_rdata;
                    r_d.issued = 1'b0;
                    if (!rd_ok)
                        r_d.st = FAULT;
                    else if (!r_q.pde[A_BIT])
                        r_d.st = UPD_PDE;
                    else if (!mem_rdata[A_BIT])
                        r_d.st = UPD_PTE;
                    else
                        r_d.st = after_xlat;
                end
            end
            UPD_PDE: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = pde_addr;
                mem_wdata = r_q.pde | (AW'(1) << A_BIT);
                r_d.pde   = mem_wdata;
                if (!r_q.big && !r_q.pte[A_BIT])
                    r_d.st = UPD_PTE;
                else
                    r_d.st = after_xlat;
            end
            UPD_PTE: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = pte_addr;
                mem_wdata = r_q.pte | (AW'(1) << A_BIT);
                r_d.pte   = mem_wdata;
                r_d.st    = after_xlat;
            end
            WAIT_COMMIT: begin
                if (commit)
                    r_d.st = fin_q[D_BIT] ? DONE : SET_DIRTY;
            end
            SET_DIRTY: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = fin_addr;
                mem_wdata = fin_q | (AW'(1) << D_BIT);
                if (r_q.big) r_d.pde = mem_wdata;
                else         r_d.pte = mem_wdata;
                r_d.st    = DONE;
            end
            DONE:    r_d.st = IDLE;
            FAULT:   r_d.st = IDLE;
            default: r_d.st = IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '{st: IDLE, default: '0};
        else        r_q <= r_d;
    end

    // R9
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done || fault) |=> !(done || fault));

    // R8
    dirty_after_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == SET_DIRTY) |-> $past(commit));

    // R5
    fault_no_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> !$past(mem_req && mem_we));

    // R6
    wb_present_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (mem_wdata[P_BIT] && mem_wdata[A_BIT]));

    // R2
    rvalid_expected_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rvalid |-> ((r_q.st == READ_PDE || r_q.st == READ_PTE) && r_q.issued));
endmodule

// File: tb/tb_page_walker.sv
module tb_page_walker;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 11;
    localparam logic [31:0] BASE = 32'h0001_0000;

    localparam logic [31:0] V_LIN [NV] = '{
        32'h0040_1234, 32'h0040_1234, 32'h0040_1234, 32'h0040_1234,
        32'h0040_1234, 32'h0040_1234, 32'h0040_1234, 32'h0040_1234,
        32'h0040_1234, 32'h0040_1234, 32'hFFFF_FFFC};
    localparam bit V_WR [NV]  = '{0,1,1,1,0,1,1,0,1,0,0};
    localparam bit V_LEN [NV] = '{0,0,0,0,0,1,0,0,0,1,0};
    localparam logic [31:0] V_PDE [NV] = '{
        32'h0002_0003, 32'h0002_0023, 32'h0002_0023, 32'h0002_0023,
        32'h0002_0002, 32'h0C00_0083, 32'h0C00_0083, 32'h0002_0003,
        32'h0002_0021, 32'h0C00_00A1, 32'h0003_0027};
    localparam logic [31:0] V_PTE [NV] = '{
        32'h0050_0001, 32'h0050_0023, 32'h0050_0063, 32'h0050_0021,
        32'h0050_0063, 32'h0070_0003, 32'h0070_0003, 32'h0000_0000,
        32'h0050_0063, 32'h0000_0000, 32'h1234_5061};
    localparam bit V_FLT [NV] = '{0,0,0,1,1,0,0,1,1,0,0};
    localparam logic [31:0] V_PHYS [NV] = '{
        32'h0050_0234, 32'h0050_0234, 32'h0050_0234, 32'h0,
        32'h0,         32'h0C00_1234, 32'h0070_0234, 32'h0,
        32'h0,         32'h0C00_1234, 32'h1234_5FFC};
    localparam logic [31:0] V_PDE_X [NV] = '{
        32'h0002_0023, 32'h0002_0023, 32'h0002_0023, 32'h0002_0023,
        32'h0002_0002, 32'h0C00_00E3, 32'h0C00_00A3, 32'h0002_0003,
        32'h0002_0021, 32'h0C00_00A1, 32'h0003_0027};
    localparam logic [31:0] V_PTE_X [NV] = '{
        32'h0050_0021, 32'h0050_0063, 32'h0050_0063, 32'h0050_0021,
        32'h0050_0063, 32'h0070_0003, 32'h0070_0063, 32'h0000_0000,
        32'h0050_0063, 32'h0000_0000, 32'h1234_5061};
    localparam int V_WRS [NV] = '{2,1,0,0,0,2,3,0,0,0,0};
    localparam int V_RDS [NV] = '{2,2,2,2,1,1,2,2,1,1,2};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_linear = '0;
    logic        req_write = 1'b0;
    logic [31:0] dir_base = BASE;
    logic        large_en = 1'b0;
    logic        commit = 1'b0;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        await_commit, done, fault;
    logic [31:0] phys_addr;

    logic [31:0] mem [logic [31:0]];
    logic        p1_v = 1'b0;
    logic [31:0] p1_d = '0;
    int wr_count = 0;
    int rd_count = 0;
    int checks = 0;
    int fails = 0;

    int          wr_at_commit;
    int          pulses;
    bit          saw_fault;
    logic [31:0] got_phys;

    always #(CLK_PERIOD/2) clk = ~clk;

    page_walker dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_linear(req_linear),
        .req_write(req_write), .dir_base(dir_base), .large_en(large_en),
        .commit(commit), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .await_commit(await_commit), .done(done), .fault(fault), .phys_addr(phys_addr)
    );

    function automatic logic [31:0] rd_word(input logic [31:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    always @(posedge clk) begin
        mem_rvalid <= p1_v;
        mem_rdata  <= p1_d;
        p1_v       <= 1'b0;
        if (mem_req && !mem_we) begin
            p1_v <= 1'b1;
            p1_d <= rd_word(mem_addr);
            rd_count = rd_count + 1;
        end
        if (mem_req && mem_we) begin
            mem[mem_addr] = mem_wdata;
            wr_count = wr_count + 1;
        end
    end

    task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: got %h expected %h", what, act, exp);
        end
    endtask

    task automatic run_vec(input int i, input int dly);
        logic [31:0] pa, ta;
        int wc, after;
        mem.delete();
        wr_count = 0;
        rd_count = 0;
        pa = BASE + {20'd0, V_LIN[i][31:22], 2'b00};
        ta = {V_PDE[i][31:12], V_LIN[i][21:12], 2'b00};
        mem[pa] = V_PDE[i];
        mem[ta] = V_PTE[i];
        @(negedge clk);
        req_valid  = 1'b1;
        req_linear = V_LIN[i];
        req_write  = V_WR[i];
        large_en   = V_LEN[i];
        @(negedge clk);
        req_valid = 1'b0;
        wc = 0; after = -1; pulses = 0; saw_fault = 0;
        got_phys = '0; wr_at_commit = -1;
        for (int c = 0; c < 400; c++) begin
            if (done) begin pulses++; got_phys = phys_addr; end
            if (fault) begin pulses++; saw_fault = 1'b1; end
            commit = 1'b0;
            if (await_commit) begin
                if (wc >= dly) begin
                    commit = 1'b1;
                    wr_at_commit = wr_count;
                end
                wc++;
            end
            if (after >= 0) after++;
            else if (pulses > 0) after = 0;
            if (after == 3) break;
            @(negedge clk);
        end
        commit = 1'b0;
        chk(pulses == 1, $sformatf("R9 pulses vec %0d", i), pulses, 1);
        chk(saw_fault == V_FLT[i], $sformatf("R5 fault vec %0d", i), saw_fault, V_FLT[i]);
        if (!V_FLT[i])
            chk(got_phys == V_PHYS[i], $sformatf("R2 R3 R4 phys vec %0d", i), got_phys, V_PHYS[i]);
        chk(rd_word(pa) == V_PDE_X[i], $sformatf("R6 R7 pde vec %0d", i), rd_word(pa), V_PDE_X[i]);
        chk(rd_word(ta) == V_PTE_X[i], $sformatf("R6 R7 pte vec %0d", i), rd_word(ta), V_PTE_X[i]);
        chk(wr_count == V_WRS[i], $sformatf("R6 writes vec %0d", i), wr_count, V_WRS[i]);
        chk(rd_count == V_RDS[i], $sformatf("R3 R4 reads vec %0d", i), rd_count, V_RDS[i]);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog R9: got hung run expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!done && !fault, "R1 pulses in reset", {30'd0, done, fault}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!mem_req && !await_commit, "R1 idle after reset", {30'd0, mem_req, await_commit}, 0);
        chk(!done && !fault, "R1 no outcome after reset", {30'd0, done, fault}, 0);

        for (int i = 0; i < NV; i++) run_vec(i, i % 3);

        // R8 dirty held back during a long commit hold-off (4 KB write)
        run_vec(1, 12);
        chk(wr_at_commit == 0, "R8 writes before commit 4k", wr_at_commit, 0);
        // R8 R7 accessed writes before commit, dirty after (table pointer with bit 7, large pages off)
        run_vec(6, 5);
        chk(wr_at_commit == 2, "R8 writes before commit walk", wr_at_commit, 2);
        // R8 large-page write, dirty in directory entry only after commit
        run_vec(5, 7);
        chk(wr_at_commit == 1, "R8 writes before commit large", wr_at_commit, 1);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule